// File: doc/BRIEF.md
# NAND Flash Read Responder

This block answers the read side of a small-page NAND flash pair sitting on one shared parallel port. The host drives two active-low chip selects, active-low read and write strobes, a command latch, an address latch and an 8-bit bus. Every control input and the bus pass through a two-stage synchroniser, after which commands and address bytes are taken on the rising edge of the write strobe, and the read pointer steps on the rising edge of the read strobe.

A read-mode command picks where in a 528-byte page the column byte lands: the first half, the second half (plus 256) or the spare area (plus 512). Three address bytes then form a linear pointer, with the column byte first, the second byte weighted by 528 x 256 and the third by 528. Each read strobe then presents the byte at the pointer and moves on by one. Storage is a reduced, power-of-two sized array per device that is filled through a preload port. The pointer is kept modulo that size. Misuse raises a sticky fault flag and leaves the device untouched.

Top module: `nand_read_responder`

## Requirements
- R1: After synchronous reset `fault` is 0, `bus_oe` is 0, `ready` is 0 while neither select is low, every device is idle, and every storage byte reads 0xFF.
- R2: Device 0 is selected when `cs0_n` is low, whatever `cs1_n` is. Device 1 is selected only when `cs1_n` is low and `cs0_n` is high. With both selects high, strobes, commands and address bytes change no device state and no output.
- R3: While a device is selected and both `rd_n` and `wr_n` are high, its bit of `ready` (bit 0 for device 0, bit 1 for device 1) is 1, the other bit is 0, and `bus_oe` is 0.
- R4: On a rising `wr_n` with `cmd_lat` high, the byte on `bus_in` is a command: 0x00, 0x01 and 0x50 select read modes 1, 2 and 3 and restart address collection, and 0xFF returns the device to idle. `cmd_lat` takes priority over `adr_lat`.
- R5: On a rising `wr_n` with `adr_lat` high and `cmd_lat` low, in a read mode, address byte 0 sets the pointer to the byte plus 0, 0x100 or 0x200 for modes 1, 2, 3. Byte 1 adds its value x 135168. Byte 2 adds its value x 528. The pointer is taken modulo MEM_BYTES, which is a power of two.
- R6: While `rd_n` is low, with `wr_n` high and both latches low, `bus_oe` is 1 and `bus_out` shows the selected device's byte at the pointer. Each rising `rd_n` advances the pointer by one, so reads stream sequential bytes and wrap at MEM_BYTES.
- R7: Storage bytes never written through the preload port read back as 0xFF.
- R8: An unknown command, an address byte while idle, a fourth address byte, a `wr_n` rise with neither latch high, or `rd_n` and `wr_n` low together on a selected device sets `fault`. `fault` stays 1 until reset, and the device's mode and pointer are unchanged.
- R9: After command 0xFF the device is idle, so a following address byte sets `fault`.
- R10: A cycle with `pre_en` high writes `pre_data` into device `pre_dev` at index `pre_addr`. A later read at that pointer returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs0_n | input | 1 | Select for device 0, active low, higher priority |
| cs1_n | input | 1 | Select for device 1, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| cmd_lat | input | 1 | Command latch enable |
| adr_lat | input | 1 | Address latch enable |
| bus_in | input | 8 | Bus byte from host |
| bus_out | output | 8 | Bus byte to host, 0 when not driving |
| bus_oe | output | 1 | Block drives the bus |
| ready | output | 2 | Per-device ready |
| fault | output | 1 | Sticky misuse flag |
| pre_en | input | 1 | Preload write enable |
| pre_dev | input | 1 | Preload device |
| pre_addr | input | $clog2(MEM_BYTES) | Preload index |
| pre_data | input | 8 | Preload byte |

## Verification
The bench builds the block with MEM_BYTES = 2048, which is small enough that the reference image can be stored in full and the preload can be repeated after each reset. It is also large enough for the third address byte to carry pointers up to and past the array end. Both devices are swept over every read mode, four column values, four values of the third byte and two values of the second byte. With 2048 entries the second byte's weight folds to zero, while mode-3 columns near 0xFF combined with large third bytes exercise wrap-around and the unprogrammed top region.

// File: rtl/nrr_pkg.sv
package nrr_pkg;

    typedef enum logic [1:0] {
        M_IDLE = 2'd0,
        M_RD1  = 2'd1,
        M_RD2  = 2'd2,
        M_RD3  = 2'd3
    } rmode_t;

    localparam int PAGE_BYTES = 528;
    localparam int HI_WEIGHT  = PAGE_BYTES * 256;

    localparam logic [7:0] CMD_RESET = 8'hFF;
    localparam logic [7:0] CMD_RD1   = 8'h00;
    localparam logic [7:0] CMD_RD2   = 8'h01;
    localparam logic [7:0] CMD_RD3   = 8'h50;

    typedef struct packed {
        logic       sel0_n;
        logic       sel1_n;
        logic       rd_n;
        logic       wr_n;
        logic       cmd;
        logic       adr;
        logic [7:0] data;
    } port_t;

    localparam port_t PORT_IDLE = '{sel0_n: 1'b1, sel1_n: 1'b1, rd_n: 1'b1,
                                    wr_n: 1'b1, cmd: 1'b0, adr: 1'b0, data: 8'h00};

    typedef struct packed {
        logic   known;
        rmode_t mode;
    } cmd_dec_t;

    function automatic cmd_dec_t decode_cmd(input logic [7:0] b);
        cmd_dec_t r;
        r.known = 1'b1;
        case (b)
            CMD_RESET: r.mode = M_IDLE;
            CMD_RD1:   r.mode = M_RD1;
            CMD_RD2:   r.mode = M_RD2;
            CMD_RD3:   r.mode = M_RD3;
            default: begin
                r.known = 1'b0;
                r.mode  = M_IDLE;
            end
        endcase
        return r;
    endfunction

    function automatic logic [9:0] mode_offset(input rmode_t m);
        case (m)
            M_RD2:   return 10'h100;
            M_RD3:   return 10'h200;
            default: return 10'h000;
        endcase
    endfunction

endpackage

// File: rtl/nrr_sync.sv
module nrr_sync #(
    parameter int         W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/nrr_store.sv
module nrr_store #(
    parameter int MEM_BYTES = 1024,
    localparam int IDX_W = $clog2(MEM_BYTES)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ld_en,
    input  logic                  ld_dev,
    input  logic [IDX_W-1:0]      ld_idx,
    input  logic [7:0]            ld_data,
    input  logic [1:0][IDX_W-1:0] rd_idx,
    output logic [1:0][7:0]       rd_data
);
    for (genvar g = 0; g < 2; g++) begin : g_dev
        logic [7:0] mem [MEM_BYTES];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
            end else if (ld_en && (ld_dev == 1'(g))) begin
                mem[ld_idx] <= ld_data;
            end
        end

        assign rd_data[g] = mem[rd_idx[g]];
    end
endmodule

// File: rtl/nrr_dev_ctl.sv
module nrr_dev_ctl
    import nrr_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_stb,
    input  logic             adr_stb,
    input  logic             rd_adv,
    input  logic [7:0]       byte_i,
    output logic [IDX_W-1:0] ptr,
    output logic             err_o
);
    rmode_t     mode;
    logic [1:0] cyc;
    cmd_dec_t   dec;

    assign dec   = decode_cmd(byte_i);
    assign err_o = (cmd_stb && !dec.known)
                || (!cmd_stb && adr_stb && (mode == M_IDLE || cyc == 2'd3));

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= M_IDLE;
            cyc  <= 2'd0;
            ptr  <= '0;
        end else if (cmd_stb) begin
            if (dec.known) begin
                mode <= dec.mode;
                cyc  <= 2'd0;
            end
        end else if (adr_stb) begin
            if (mode != M_IDLE && cyc != 2'd3) begin
                case (cyc)
                    2'd0:    ptr <= IDX_W'(32'(byte_i) | 32'(mode_offset(mode)));
                    2'd1:    ptr <= IDX_W'(32'(ptr) + 32'(byte_i) * HI_WEIGHT);
                    default: ptr <= IDX_W'(32'(ptr) + 32'(byte_i) * PAGE_BYTES);
                endcase
                cyc <= cyc + 2'd1;
            end
        end else if (rd_adv) begin
            ptr <= ptr + 1'b1;
        end
    end

    assert_reset_cmd_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (cmd_stb && byte_i == CMD_RESET) |=> (mode == M_IDLE));

    assert_ptr_step_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_adv && !cmd_stb && !adr_stb) |=> (ptr == $past(ptr) + 1'b1));

    assert_fault_keeps_state_R8: assert property (@(posedge clk) disable iff (rst)
        err_o |=> (mode == $past(mode) && ptr == $past(ptr) && cyc == $past(cyc)));

    assert_cycle_cap_R8: assert property (@(posedge clk) disable iff (rst)
        (cyc == 2'd3) |=> (cyc == 2'd3 || $past(cmd_stb)));
endmodule

// File: rtl/nand_read_responder.sv
module nand_read_responder
    import nrr_pkg::*;
#(
    parameter int MEM_BYTES = 1024,
    localparam int IDX_W = $clog2(MEM_BYTES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs0_n,
    input  logic             cs1_n,
    input  logic             rd_n,
    input  logic             wr_n,
    input  logic             cmd_lat,
    input  logic             adr_lat,
    input  logic [7:0]       bus_in,
    output logic [7:0]       bus_out,
    output logic             bus_oe,
    output logic [1:0]       ready,
    output logic             fault,
    input  logic             pre_en,
    input  logic             pre_dev,
    input  logic [IDX_W-1:0] pre_addr,
    input  logic [7:0]       pre_data
);
    localparam int PW = $bits(port_t);

    port_t raw, syn;
    logic  wr_q, rd_q;

    assign raw = '{sel0_n: cs0_n, sel1_n: cs1_n, rd_n: rd_n, wr_n: wr_n,
                   cmd: cmd_lat, adr: adr_lat, data: bus_in};

    nrr_sync #(.W(PW), .RST_VAL(PORT_IDLE)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (syn)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q <= 1'b1;
            rd_q <= 1'b1;
        end else begin
            wr_q <= syn.wr_n;
            rd_q <= syn.rd_n;
        end
    end

    logic [1:0] sel;
    logic       any_sel, wr_rise, rd_rise;
    logic       wr_cmd, wr_adr, wr_bad, rd_adv, clash;

    assign sel[0]  = !syn.sel0_n;
    assign sel[1]  = syn.sel0_n && !syn.sel1_n;
    assign any_sel = |sel;

    assign wr_rise = syn.wr_n && !wr_q;
    assign rd_rise = syn.rd_n && !rd_q;
    assign wr_cmd  = wr_rise && syn.cmd;
    assign wr_adr  = wr_rise && !syn.cmd && syn.adr;
    assign wr_bad  = wr_rise && !syn.cmd && !syn.adr;
    assign rd_adv  = rd_rise && !syn.cmd && !syn.adr;
    assign clash   = !syn.rd_n && !syn.wr_n;

    logic [1:0][IDX_W-1:0] ptr;
    logic [1:0][7:0]       rd_data;
    logic [1:0]            dev_err;

    for (genvar g = 0; g < 2; g++) begin : g_ctl
        nrr_dev_ctl #(.IDX_W(IDX_W)) u_ctl (
            .clk     (clk),
            .rst     (rst),
            .cmd_stb (wr_cmd && sel[g]),
            .adr_stb (wr_adr && sel[g]),
            .rd_adv  (rd_adv && sel[g]),
            .byte_i  (syn.data),
            .ptr     (ptr[g]),
            .err_o   (dev_err[g])
        );
    end

    nrr_store #(.MEM_BYTES(MEM_BYTES)) u_store (
        .clk     (clk),
        .rst     (rst),
        .ld_en   (pre_en),
        .ld_dev  (pre_dev),
        .ld_idx  (pre_addr),
        .ld_data (pre_data),
        .rd_idx  (ptr),
        .rd_data (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fault <= 1'b0;
        end else if (any_sel && ((|dev_err) || wr_bad || clash)) begin
            fault <= 1'b1;
        end
    end

    assign ready[0] = sel[0] && syn.rd_n && syn.wr_n;
    assign ready[1] = sel[1] && syn.rd_n && syn.wr_n;
    assign bus_oe   = any_sel && !syn.rd_n && syn.wr_n && !syn.cmd && !syn.adr;
    assign bus_out  = bus_oe ? rd_data[sel[1]] : 8'h00;

    assert_ready_onehot_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ready));

    assert_drive_not_ready_R6: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> (ready == 2'b00));

    assert_fault_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        fault |=> fault);

    assert_unselected_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !any_sel |=> $stable(fault));
endmodule

// File: tb/sim_nand_read_responder.sv
module sim_nand_read_responder;
    localparam int MEM   = 2048;
    localparam int IDX_W = $clog2(MEM);
    localparam int UNPROG = 1800;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs0_n = 1'b1, cs1_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic cmd_lat = 1'b0, adr_lat = 1'b0;
    logic [7:0] bus_in = 8'h00;
    logic [7:0] bus_out;
    logic bus_oe, fault;
    logic [1:0] ready;
    logic pre_en = 1'b0, pre_dev = 1'b0;
    logic [IDX_W-1:0] pre_addr = '0;
    logic [7:0] pre_data = 8'h00;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    nand_read_responder #(.MEM_BYTES(MEM)) u0 (
        .clk(clk), .rst(rst), .cs0_n(cs0_n), .cs1_n(cs1_n), .rd_n(rd_n),
        .wr_n(wr_n), .cmd_lat(cmd_lat), .adr_lat(adr_lat), .bus_in(bus_in),
        .bus_out(bus_out), .bus_oe(bus_oe), .ready(ready), .fault(fault),
        .pre_en(pre_en), .pre_dev(pre_dev), .pre_addr(pre_addr), .pre_data(pre_data)
    );

    function automatic logic [7:0] img(input int d, input int a);
        if (a >= UNPROG) return 8'hFF;
        return 8'((a * 37 + d * 101 + (a >> 8)) & 255);
    endfunction

    function automatic int ptr_of(input int m, input int col, input int b1, input int b2);
        int off;
        off = (m == 1) ? 256 : (m == 2) ? 512 : 0;
        return ((col | off) + b1 * 135168 + b2 * 528) % MEM;
    endfunction

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cs0_n = 1'b1; cs1_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
        cmd_lat = 1'b0; adr_lat = 1'b0; pre_en = 1'b0;
        idle(3);
        rst = 1'b0;
        idle(4);
    endtask

    task automatic preload();
        for (int d = 0; d < 2; d++) begin
            for (int a = 0; a < UNPROG; a++) begin
                @(negedge clk);
                pre_en = 1'b1; pre_dev = 1'(d); pre_addr = IDX_W'(a); pre_data = img(d, a);
            end
        end
        @(negedge clk);
        pre_en = 1'b0;
    endtask

    task automatic select(input int d);
        @(negedge clk);
        cs0_n = (d == 0) ? 1'b0 : 1'b1;
        cs1_n = (d == 1) ? 1'b0 : 1'b1;
        idle(4);
    endtask

    task automatic wr(input logic c, input logic a, input logic [7:0] b);
        @(negedge clk);
        cmd_lat = c; adr_lat = a; bus_in = b;
        idle(3);
        wr_n = 1'b0;
        idle(4);
        wr_n = 1'b1;
        idle(4);
        cmd_lat = 1'b0; adr_lat = 1'b0;
        idle(2);
    endtask

    task automatic rd(output logic [7:0] v, output logic oe);
        @(negedge clk);
        rd_n = 1'b0;
        idle(5);
        v = bus_out; oe = bus_oe;
        rd_n = 1'b1;
        idle(5);
    endtask

    task automatic setup(input int m, input int col, input int b1, input int b2);
        logic [7:0] cmds [3];
        cmds[0] = 8'h00; cmds[1] = 8'h01; cmds[2] = 8'h50;
        wr(1'b1, 1'b0, cmds[m]);
        wr(1'b0, 1'b1, 8'(col));
        wr(1'b0, 1'b1, 8'(b1));
        wr(1'b0, 1'b1, 8'(b2));
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic oe;
        int cols [4];
        cols[0] = 0; cols[1] = 1; cols[2] = 8'h7F; cols[3] = 8'hFF;

        do_reset();
        // R1: reset state
        chk(fault, 0, "R1 fault after reset");
        chk(bus_oe, 0, "R1 bus_oe after reset");
        chk(ready, 0, "R1 ready unselected");
        select(1);
        setup(0, 3, 0, 0);
        rd(v, oe);
        chk(v, 8'hFF, "R1 erased byte after reset");
        chk(fault, 0, "R1 no fault after valid sequence");

        preload();

        // R3: ready per device
        select(0);
        chk(ready, 2'b01, "R3 ready dev0");
        chk(bus_oe, 0, "R3 bus released dev0");
        select(1);
        chk(ready, 2'b10, "R3 ready dev1");

        // R4 R5 R6 R7 R10: full sweep
        for (int d = 0; d < 2; d++) begin
            select(d);
            for (int m = 0; m < 3; m++)
                for (int ci = 0; ci < 4; ci++)
                    for (int b2 = 0; b2 < 4; b2++)
                        for (int b1 = 0; b1 < 2; b1++) begin
                            int p;
                            p = ptr_of(m, cols[ci], b1, b2);
                            setup(m, cols[ci], b1, b2);
                            for (int k = 0; k < 4; k++) begin
                                rd(v, oe);
                                chk(oe, 1, "R6 bus driven on read");
                                chk(v, img(d, (p + k) % MEM), "R5 R6 R7 R10 sequential read");
                            end
                        end
        end
        chk(fault, 0, "R4 no fault during valid sweep");

        // R2: priority and unselected bus
        select(1);
        setup(0, 10, 0, 1);
        rd(v, oe);
        chk(v, img(1, 538), "R2 dev1 prime");
        @(negedge clk); cs0_n = 1'b0; cs1_n = 1'b0; idle(4);
        chk(ready, 2'b01, "R2 both low selects dev0");
        setup(0, 5, 0, 1);
        rd(v, oe);
        chk(v, img(0, 533), "R2 dev0 wins priority");
        select(1);
        rd(v, oe);
        chk(v, img(1, 539), "R2 dev1 untouched by priority");
        select(2);
        wr(1'b1, 1'b0, 8'hFF);
        wr(1'b0, 1'b1, 8'h20);
        wr(1'b1, 1'b0, 8'h42);
        @(negedge clk); rd_n = 1'b0; idle(5);
        chk(bus_oe, 0, "R2 no drive unselected");
        chk(ready, 0, "R2 no ready unselected");
        rd_n = 1'b1; idle(5);
        chk(fault, 0, "R2 no fault unselected");
        select(1);
        rd(v, oe);
        chk(v, img(1, 540), "R2 dev1 pointer kept");

        // R8: unknown command keeps state
        select(0);
        setup(0, 20, 0, 0);
        rd(v, oe);
        wr(1'b1, 1'b0, 8'h42);
        chk(fault, 1, "R8 unknown command");
        rd(v, oe);
        chk(v, img(0, 21), "R8 state kept after unknown command");
        idle(20);
        chk(fault, 1, "R8 fault sticky");

        // R8: fourth address byte
        do_reset(); preload(); select(0);
        setup(1, 4, 0, 1);
        chk(fault, 0, "R8 three bytes clean");
        wr(1'b0, 1'b1, 8'h33);
        chk(fault, 1, "R8 fourth address byte");
        rd(v, oe);
        chk(v, img(0, 260 + 528), "R8 pointer kept after fourth byte");

        // R8: address while idle
        do_reset(); select(1);
        wr(1'b0, 1'b1, 8'h01);
        chk(fault, 1, "R8 address while idle");

        // R8: write strobe with no latch
        do_reset(); select(0);
        wr(1'b0, 1'b0, 8'h00);
        chk(fault, 1, "R8 bare write strobe");

        // R8: both strobes low
        do_reset(); select(0);
        @(negedge clk); rd_n = 1'b0; wr_n = 1'b0; idle(5);
        rd_n = 1'b1; wr_n = 1'b1; idle(5);
        chk(fault, 1, "R8 strobe clash");

        // R9: reset command returns to idle
        do_reset(); select(0);
        wr(1'b1, 1'b0, 8'h00);
        chk(fault, 0, "R9 read mode set");
        wr(1'b1, 1'b0, 8'hFF);
        chk(fault, 0, "R9 reset command valid");
        wr(1'b0, 1'b1, 8'h05);
        chk(fault, 1, "R9 idle after reset command");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule